// File: doc/BRIEF.md
# 32-bit Integer Arithmetic-Logic Unit with Overflow Detection

This block performs one integer operation per clock on two operand words. A 4-bit operation code picks the operation: signed or unsigned addition, signed or unsigned subtraction, one of four bitwise functions, or a signed or unsigned less-than comparison. The result word, a carry flag and a signed-overflow flag are captured in output registers, so they appear one clock after the operands and code are presented.

There is a single ripple-carry adder. Subtraction and both comparisons use it with the second operand inverted and the carry-in forced to one. Signed overflow is the XOR of the carry into the top bit and the carry out of it, and it is reported only by the signed add and subtract codes. The signed comparison corrects the difference's sign bit by that same overflow term, so it gives the right answer even when the difference itself does not fit in the word. The unsigned comparison reads the adder's carry-out, where a carry of zero means a borrow.

Top module: `int_alu32`

## Requirements
- R1: A high `rst` sampled on a rising clock edge clears `res_q`, `cout_q` and `ovf_q` to zero on that edge.
- R2: Outputs are registered. The operands and code sampled on one rising edge determine the outputs from that edge until the next one, and the outputs do not change between edges.
- R3: Codes 0 (signed add) and 1 (unsigned add): `res_q` = (A + B) mod 2^32 and `cout_q` = carry out of bit 31.
- R4: Codes 2 (signed subtract) and 3 (unsigned subtract): `res_q` = (A − B) mod 2^32, computed as A + ~B + 1. `cout_q` is the carry out of bit 31 of that sum, which is 1 exactly when A ≥ B taken as unsigned numbers.
- R5: For codes 0 and 2, `ovf_q` is 1 exactly when the true signed result lies outside [−2^31, 2^31−1]. Adding operands of opposite sign never sets it, and subtracting operands of equal sign never sets it.
- R6: Codes 1 and 3 always leave `ovf_q` at 0.
- R7: Codes 4 (AND), 5 (OR), 6 (XOR) and 7 (NOR) give the bitwise function of A and B, with `cout_q` = 0 and `ovf_q` = 0.
- R8: Code 10 (signed less-than): bit 0 of `res_q` is 1 exactly when A < B as two's-complement numbers, and this holds even when A − B overflows. Bits 31..1 are 0, `cout_q` is the carry of A + ~B + 1, and `ovf_q` = 0.
- R9: Code 11 (unsigned less-than): bit 0 of `res_q` is 1 exactly when A < B as unsigned numbers, which is when A + ~B + 1 produces no carry. Bits 31..1 are 0, `cout_q` is that carry, and `ovf_q` = 0.
- R10: Codes 8, 9 and 12 to 15 give `res_q` = 0, `cout_q` = 0 and `ovf_q` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | 32 | First operand (A) |
| opnd_b | input | 32 | Second operand (B) |
| op_sel | input | 4 | Operation code |
| res_q | output | 32 | Registered result word |
| cout_q | output | 1 | Registered carry flag |
| ovf_q | output | 1 | Registered signed-overflow flag |

## Verification
The adder is driven with boundary operands: the largest positive value plus one, the most negative value minus one, minus one plus one, and two most-negative values added. These show apart overflow without carry, carry without overflow, and both at once, and they separate the signed from the unsigned codes on identical data. For comparisons the operand pairs are chosen so that A − B overflows, which separates a correct signed less-than from one that only reads the sign bit, and each pair is also sent with the unsigned code, where the answer is the opposite. Logic codes use complementary and checkerboard patterns that give a different word for each function, and a pseudo-random sweep across all ten valid codes is checked against an arithmetic model built on wider integers.

// File: rtl/int_alu32_pkg.sv
`timescale 1ns/1ps
package int_alu32_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD_S  = 4'h0,
    OP_ADD_U  = 4'h1,
    OP_SUB_S  = 4'h2,
    OP_SUB_U  = 4'h3,
    OP_AND    = 4'h4,
    OP_OR     = 4'h5,
    OP_XOR    = 4'h6,
    OP_NOR    = 4'h7,
    OP_LT_S   = 4'hA,
    OP_LT_U   = 4'hB
  } alu_op_e;
endpackage

// File: rtl/alu_ripple_add.sv
`timescale 1ns/1ps
module alu_ripple_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_into_msb,
  output logic         c_out
);
  logic [W:0] c;
  assign c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]  = a[i] ^ b[i] ^ c[i];
    assign c[i+1]  = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
  end

  assign c_into_msb = c[W-1];
  assign c_out      = c[W];
endmodule

// File: rtl/alu_bitwise.sv
`timescale 1ns/1ps
module alu_bitwise #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   fsel,   // 0 and, 1 or, 2 xor, 3 nor
  output logic [W-1:0] y
);
  always_comb begin
    unique case (fsel)
      2'd0:    y = a & b;
      2'd1:    y = a | b;
      2'd2:    y = a ^ b;
      default: y = ~(a | b);
    endcase
  end
endmodule

// File: rtl/int_alu32.sv
`timescale 1ns/1ps
module int_alu32
  import int_alu32_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   opnd_a,
  input  logic [W-1:0]   opnd_b,
  input  logic [OPW-1:0] op_sel,
  output logic [W-1:0]   res_q,
  output logic           cout_q,
  output logic           ovf_q
);
  localparam int MSB = W - 1;

  // Subtract path is shared by both subtracts and both compares
  logic         use_sub;
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic         c_msb_in;
  logic         c_top;
  logic         ovf_raw;
  logic         lt_s_bit;
  logic         lt_u_bit;
  logic [W-1:0] logic_y;

  assign use_sub = (op_sel == OP_SUB_S) || (op_sel == OP_SUB_U) ||
                   (op_sel == OP_LT_S)  || (op_sel == OP_LT_U);
  assign b_eff   = use_sub ? ~opnd_b : opnd_b;

  alu_ripple_add #(.W(W)) u_add (
    .a          (opnd_a),
    .b          (b_eff),
    .cin        (use_sub),
    .sum        (sum),
    .c_into_msb (c_msb_in),
    .c_out      (c_top)
  );

  alu_bitwise #(.W(W)) u_bitw (
    .a    (opnd_a),
    .b    (opnd_b),
    .fsel (op_sel[1:0]),
    .y    (logic_y)
  );

  assign ovf_raw  = c_msb_in ^ c_top;
  assign lt_s_bit = sum[MSB] ^ ovf_raw;
  assign lt_u_bit = ~c_top;

  logic [W-1:0] res_d;
  logic         cout_d;
  logic         ovf_d;

  always_comb begin
    res_d  = '0;
    cout_d = 1'b0;
    ovf_d  = 1'b0;
    case (op_sel)
      OP_ADD_S, OP_SUB_S: begin
        res_d  = sum;
        cout_d = c_top;
        ovf_d  = ovf_raw;
      end
      OP_ADD_U, OP_SUB_U: begin
        res_d  = sum;
        cout_d = c_top;
      end
      OP_AND, OP_OR, OP_XOR, OP_NOR: begin
        res_d  = logic_y;
      end
      OP_LT_S: begin
        res_d  = {{(W-1){1'b0}}, lt_s_bit};
        cout_d = c_top;
      end
      OP_LT_U: begin
        res_d  = {{(W-1){1'b0}}, lt_u_bit};
        cout_d = c_top;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      cout_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      res_q  <= res_d;
      cout_q <= cout_d;
      ovf_q  <= ovf_d;
    end
  end

  // R1: reset clears every output register
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (res_q == '0) && !cout_q && !ovf_q);

  // R6: unsigned add and subtract never report overflow
  a_r6_unsigned_no_ovf: assert property (@(posedge clk) disable iff (rst)
    ((op_sel == OP_ADD_U) || (op_sel == OP_SUB_U)) |=> !ovf_q);

  // R5: opposite-sign addition cannot overflow
  a_r5_mixed_add_no_ovf: assert property (@(posedge clk) disable iff (rst)
    ((op_sel == OP_ADD_S) && (opnd_a[MSB] != opnd_b[MSB])) |=> !ovf_q);

  // R5: same-sign subtraction cannot overflow
  a_r5_like_sub_no_ovf: assert property (@(posedge clk) disable iff (rst)
    ((op_sel == OP_SUB_S) && (opnd_a[MSB] == opnd_b[MSB])) |=> !ovf_q);

  // R7: logic codes leave both flags clear
  a_r7_logic_no_flags: assert property (@(posedge clk) disable iff (rst)
    (op_sel[3:2] == 2'b01) |=> !cout_q && !ovf_q);

  // R8 and R9: comparisons write only bit 0 and never flag overflow
  a_r8_compare_narrow: assert property (@(posedge clk) disable iff (rst)
    ((op_sel == OP_LT_S) || (op_sel == OP_LT_U)) |=>
      (res_q[MSB:1] == '0) && !ovf_q);

  // R10: unassigned codes give all zeros
  a_r10_unused_zero: assert property (@(posedge clk) disable iff (rst)
    ((op_sel == 4'h8) || (op_sel == 4'h9) || (op_sel[3:2] == 2'b11)) |=>
      (res_q == '0) && !cout_q && !ovf_q);
endmodule

// File: tb/int_alu32_tb.sv
`timescale 1ns/1ps
module int_alu32_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [3:0]  op_sel = '0;
  logic [31:0] res_q;
  logic        cout_q;
  logic        ovf_q;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] lfsr = 32'h1234_5679;

  always #4 clk = ~clk;   // 125 MHz

  int_alu32 dut_i (
    .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .op_sel(op_sel), .res_q(res_q), .cout_q(cout_q), .ovf_q(ovf_q)
  );

  // Reference model written from the requirements with wide integers
  function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                input logic [3:0] op, output logic [31:0] r,
                                output logic c, output logic v);
    logic [32:0] s;
    r = '0; c = 1'b0; v = 1'b0;
    case (op)
      4'h0, 4'h1: begin
        s = {1'b0, a} + {1'b0, b};
        r = s[31:0]; c = s[32];
        v = (op == 4'h0) && (a[31] == b[31]) && (r[31] != a[31]);
      end
      4'h2, 4'h3: begin
        s = {1'b0, a} + {1'b0, ~b} + 33'd1;
        r = s[31:0]; c = s[32];
        v = (op == 4'h2) && (a[31] != b[31]) && (r[31] != a[31]);
      end
      4'h4: r = a & b;
      4'h5: r = a | b;
      4'h6: r = a ^ b;
      4'h7: r = ~(a | b);
      4'hA: begin r = {31'd0, ($signed(a) < $signed(b))}; c = (a >= b); end
      4'hB: begin r = {31'd0, (a < b)}; c = (a >= b); end
      default: ;
    endcase
  endfunction

  task automatic compare(input string tag, input logic [31:0] er,
                         input logic ec, input logic ev);
    n_vec++;
    if (res_q !== er || cout_q !== ec || ovf_q !== ev) begin
      n_bad++;
      $display("FAIL %s: got res=%h c=%b v=%b expected res=%h c=%b v=%b",
               tag, res_q, cout_q, ovf_q, er, ec, ev);
    end
  endtask

  task automatic apply(input string tag, input logic [31:0] a,
                       input logic [31:0] b, input logic [3:0] op);
    logic [31:0] er; logic ec, ev;
    @(negedge clk);
    opnd_a = a; opnd_b = b; op_sel = op;
    @(negedge clk);
    model(a, b, op, er, ec, ev);
    compare($sformatf("%s op=%h a=%h b=%h", tag, op, a, b), er, ec, ev);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; opnd_a = 32'hFFFF_FFFF; opnd_b = 32'h1; op_sel = 4'h0;
    @(negedge clk);
    compare("R1 reset held", '0, 1'b0, 1'b0);
    rst = 1'b0;
    apply("R1 pre-reset op", 32'h7FFF_FFFF, 32'h1, 4'h0);
    rst = 1'b1;
    @(negedge clk);
    compare("R1 reset after op", '0, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_latency();
    apply("R2 first", 32'h0000_0005, 32'h0000_0003, 4'h0);
    @(negedge clk);
    opnd_a = 32'hA5A5_0000; opnd_b = 32'h0F0F_0F0F; op_sel = 4'h6;
    #1;
    compare("R2 holds until edge", 32'h0000_0008, 1'b0, 1'b0);
    @(negedge clk);
    compare("R2 new after edge", 32'hAAAA_0F0F, 1'b0, 1'b0);
  endtask

  task automatic t_add();
    apply("R3 small", 32'd100, 32'd23, 4'h0);
    apply("R3 wrap carry", 32'hFFFF_FFFF, 32'h1, 4'h0);
    apply("R5 pos overflow", 32'h7FFF_FFFF, 32'h1, 4'h0);
    apply("R5 neg overflow", 32'h8000_0000, 32'h8000_0000, 4'h0);
    apply("R5 mixed no ovf", 32'h7FFF_FFFF, 32'h8000_0000, 4'h0);
  endtask

  task automatic t_sub();
    apply("R4 small", 32'd50, 32'd8, 4'h2);
    apply("R4 borrow", 32'd3, 32'd7, 4'h2);
    apply("R4 equal", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'h2);
    apply("R5 sub ovf min-1", 32'h8000_0000, 32'h1, 4'h2);
    apply("R5 sub ovf 0-min", 32'h0, 32'h8000_0000, 4'h2);
    apply("R5 like sub no ovf", 32'hFFFF_FFF0, 32'h8000_0000, 4'h2);
  endtask

  task automatic t_unsigned();
    apply("R6 addu ovf pattern", 32'h7FFF_FFFF, 32'h1, 4'h1);
    apply("R6 addu neg pair", 32'h8000_0000, 32'h8000_0000, 4'h1);
    apply("R6 subu ovf pattern", 32'h8000_0000, 32'h1, 4'h3);
    apply("R6 subu borrow", 32'h0, 32'h8000_0000, 4'h3);
  endtask

  task automatic t_logic();
    for (int k = 4; k < 8; k++) begin
      apply("R7 checker", 32'hAAAA_5555, 32'hFF00_F0F0, 4'(k));
      apply("R7 ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'(k));
    end
  endtask

  task automatic t_slt();
    apply("R8 neg<pos", 32'h8000_0000, 32'h1, 4'hA);
    apply("R8 pos<neg false", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'hA);
    apply("R8 min<max", 32'h8000_0000, 32'h7FFF_FFFF, 4'hA);
    apply("R8 max<min false", 32'h7FFF_FFFF, 32'h8000_0000, 4'hA);
    apply("R8 equal", 32'h1234_5678, 32'h1234_5678, 4'hA);
    apply("R8 -2<-1", 32'hFFFF_FFFE, 32'hFFFF_FFFF, 4'hA);
  endtask

  task automatic t_sltu();
    apply("R9 big<1 false", 32'h8000_0000, 32'h1, 4'hB);
    apply("R9 max<ffff", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'hB);
    apply("R9 equal", 32'h0, 32'h0, 4'hB);
    apply("R9 0<1", 32'h0, 32'h1, 4'hB);
  endtask

  task automatic t_unused();
    for (int k = 8; k < 16; k++) begin
      if (k != 10 && k != 11)
        apply("R10 unused code", 32'hFFFF_FFFF, 32'h0000_0001, 4'(k));
    end
  endtask

  task automatic t_sweep();
    logic [3:0] ops [10] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hA, 4'hB};
    logic [31:0] a, b;
    for (int n = 0; n < 400; n++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      a = lfsr;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      b = (n % 7 == 0) ? {~a[31], a[30:0]} : lfsr;
      apply("R3/R4/R7/R8/R9 sweep", a, b, ops[n % 10]);
    end
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_latency();
    t_add();
    t_sub();
    t_unsigned();
    t_logic();
    t_slt();
    t_sltu();
    t_unused();
    t_sweep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule